// File: doc/BRIEF.md
# Quad-Data-Rate Four-Word Burst SRAM Controller

This block sits on the host side of a separate-I/O static RAM. That RAM moves two data words per clock cycle and transfers four words per access. The block takes simple user requests on two independent channels, one for reads and one for writes. Each channel has a valid/ready handshake. The block turns each accepted request into the memory's pin sequence: an active-low port select held for one cycle together with the burst start address, then four data beats. The whole design runs on a single clock. Each memory cycle is modelled as a pair of words: the word for the rising half and the word for the falling half.

A write request carries all four words and all four byte-enable masks at once. The controller stores them and drives them out as two beat pairs in the two cycles after the select. Read data comes back from the memory one and a half cycles after the address is latched, as two beat pairs. The controller captures them and returns them to the user. A parameter chooses the return format: either one strobe per beat pair, or one strobe carrying the whole packed burst.

The memory refuses a second start of the same kind on the very next clock edge. The controller therefore keeps each channel's ready low for the cycle after an accepted request. The read and write ports are not arbitrated against each other, so both can launch on the same edge.

Top module: `qdr_burst_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, both port selects are high, both readies are high, the read valid is low, all byte selects are high and the write data pins are zero.
- R2: A write accepted at a clock edge (wrValid and wrReady both high) makes memWrSelN low for exactly the following cycle t, with memWrAddr equal to the request address.
- R3: Word i of a write sits in wrData[i*DATA_W +: DATA_W]. Its byte enables sit in wrByteEn[i*BYTES +: BYTES], where bit b of a mask covers bits [8b +: 8] of the word. In cycle t+1 the rising-half pins carry word 0 and the falling-half pins carry word 1. In cycle t+2 the rising-half pins carry word 2 and the falling-half pins carry word 3. The byte selects in those cycles are the bitwise inverse of the matching enables. In every other cycle the byte selects are all high and the write data pins are zero.
- R4: wrReady is low in cycle t after an accepted write, so memWrSelN is never low in two consecutive cycles. A request held continuously launches once every second cycle.
- R5: A read accepted at a clock edge makes memRdSelN low for exactly the following cycle t, with memRdAddr equal to the request address.
- R6: rdReady is low in cycle t after an accepted read, so memRdSelN is never low in two consecutive cycles. A request held continuously launches once every second cycle.
- R7: The read-data pins are sampled at the end of cycle t+2 (rising half = word A, falling half = word A+1) and at the end of cycle t+3 (words A+2 and A+3). Values on those pins in any other cycle have no effect on the user output.
- R8: With PACKED_RD = 0, rdDataValid is high in cycle t+3 with rdData = {word A+1, word A} (word A in the low half) and rdLast low. It is high again in cycle t+4 with {word A+3, word A+2} and rdLast high.
- R9: With PACKED_RD = 1, rdDataValid is high only in cycle t+4, with word A+i in rdData[i*DATA_W +: DATA_W] and rdLast high.
- R10: A read and a write requested on the same edge both launch on that edge, with both port selects low in the same cycle.
- R11: When no request is presented, both port selects stay high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrValid | input | 1 | Write request present |
| wrReady | output | 1 | Write request can be taken this edge |
| wrAddr | input | ADDR_W | Burst start address of the write |
| wrData | input | 4*DATA_W | Four write words, word i at [i*DATA_W +: DATA_W] |
| wrByteEn | input | 4*DATA_W/8 | Active-high byte enables, one mask per word |
| rdValid | input | 1 | Read request present |
| rdReady | output | 1 | Read request can be taken this edge |
| rdAddr | input | ADDR_W | Burst start address of the read |
| rdDataValid | output | 1 | Read data valid strobe |
| rdLast | output | 1 | Marks the final strobe of a read burst |
| rdData | output | 2*DATA_W or 4*DATA_W | Beat pair (PACKED_RD=0) or whole burst (PACKED_RD=1) |
| memWrSelN | output | 1 | Active-low write port select |
| memWrAddr | output | ADDR_W | Write burst address to memory |
| memByteSelRiseN | output | DATA_W/8 | Active-low byte selects, rising half |
| memByteSelFallN | output | DATA_W/8 | Active-low byte selects, falling half |
| memWrDataRise | output | DATA_W | Write word, rising half |
| memWrDataFall | output | DATA_W | Write word, falling half |
| memRdSelN | output | 1 | Active-low read port select |
| memRdAddr | output | ADDR_W | Read burst address to memory |
| memRdDataRise | input | DATA_W | Read word from memory, rising half |
| memRdDataFall | input | DATA_W | Read word from memory, falling half |

## Verification
Sixteen write bursts use start addresses spread across the whole space, including one that wraps past the top. Each burst has a different byte-enable mask, so any swap of beat order, half, or lane inversion shows up on the pins. The bench then reads every burst back, plus one address that was never written. This separates correct merging of partial writes from stale data and from words that were captured in the wrong cycle. Outside the capture cycles, the memory model drives junk on the read pins.

A final pattern holds both request channels high together for eight cycles. It tells apart correct every-other-edge spacing, simultaneous launches on the two ports, and the number of strobes each return format produces.

// File: rtl/qdr_burst_pkg.sv
package qdr_burst_pkg;

  // words per memory access
  localparam int BURST_LEN = 4;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic wrLaunch;  // write request accepted this edge
    logic wrBeatLo;  // load words 0/1 onto the pins this edge
    logic wrBeatHi;  // load words 2/3 onto the pins this edge
    logic rdLaunch;  // read request accepted this edge
    logic rdCapLo;   // capture first read pair this edge
    logic rdCapHi;   // capture second read pair this edge
  } seqStrobes_t;

endpackage

// File: rtl/qdr_burst_seq.sv
module qdr_burst_seq
  import qdr_burst_pkg::*;
#(
  parameter int RD_CAP_LAT = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  output logic        wrReady,
  input  logic        rdValid,
  output logic        rdReady,
  output logic        memWrSelN,
  output logic        memRdSelN,
  output seqStrobes_t strb
);

  localparam int PIPE_LEN = RD_CAP_LAT + 1;

  logic wrAct, wrPh1;
  logic rdAct;
  logic [PIPE_LEN:1] rdPipe;
  logic wrFire, rdFire;

  // a port that issued last edge must skip this edge
  assign wrReady = !wrAct;
  assign rdReady = !rdAct;
  assign wrFire  = wrValid && wrReady;
  assign rdFire  = rdValid && rdReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAct  <= 1'b0;
      wrPh1  <= 1'b0;
      rdAct  <= 1'b0;
      rdPipe <= '0;
    end else begin
      wrAct  <= wrFire;
      wrPh1  <= wrAct;
      rdAct  <= rdFire;
      rdPipe <= {rdPipe[PIPE_LEN-1:1], rdAct};
    end
  end

  assign memWrSelN = !wrAct;
  assign memRdSelN = !rdAct;

  always_comb begin
    strb          = '0;
    strb.wrLaunch = wrFire;
    strb.wrBeatLo = wrAct;
    strb.wrBeatHi = wrPh1;
    strb.rdLaunch = rdFire;
    strb.rdCapLo  = rdPipe[RD_CAP_LAT];
    strb.rdCapHi  = rdPipe[PIPE_LEN];
  end

  // R4
  // wr_spacing_chk
  wr_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWrSelN |=> memWrSelN);

  // R6
  // rd_spacing_chk
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memRdSelN |=> memRdSelN);

  // R2
  // wr_launch_chk
  wr_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memWrSelN |-> $past(wrValid));

  // R5
  // rd_launch_chk
  rd_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    !memRdSelN |-> $past(rdValid));

endmodule

// File: rtl/qdr_burst_dp.sv
module qdr_burst_dp
  import qdr_burst_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16,
  parameter int PACKED_RD = 0
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  seqStrobes_t                               strb,
  input  logic [ADDR_W-1:0]                         wrAddr,
  input  logic [BURST_LEN*DATA_W-1:0]               wrData,
  input  logic [BURST_LEN*(DATA_W/8)-1:0]           wrByteEn,
  input  logic [ADDR_W-1:0]                         rdAddr,
  output logic                                      rdDataValid,
  output logic                                      rdLast,
  output logic [(PACKED_RD != 0 ? 4 : 2)*DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0]                         memWrAddr,
  output logic [DATA_W/8-1:0]                       memByteSelRiseN,
  output logic [DATA_W/8-1:0]                       memByteSelFallN,
  output logic [DATA_W-1:0]                         memWrDataRise,
  output logic [DATA_W-1:0]                         memWrDataFall,
  output logic [ADDR_W-1:0]                         memRdAddr,
  input  logic [DATA_W-1:0]                         memRdDataRise,
  input  logic [DATA_W-1:0]                         memRdDataFall
);

  localparam int BYTES  = DATA_W / 8;
  localparam int PAIR_W = 2 * DATA_W;
  localparam int PAIR_B = 2 * BYTES;
  localparam int RD_W   = (PACKED_RD != 0 ? 4 : 2) * DATA_W;

  logic [ADDR_W-1:0]              wrAddrQ, rdAddrQ;
  logic [BURST_LEN*DATA_W-1:0]    wrBufQ;
  logic [BURST_LEN*BYTES-1:0]     enBufQ;
  logic [PAIR_W-1:0]              pairData;
  logic [PAIR_B-1:0]              pairEn;
  logic [DATA_W-1:0]              riseQ, fallQ;
  logic [BYTES-1:0]               selRiseNQ, selFallNQ;
  logic                           beatLo, beatHi, capLo, capHi;

  assign beatLo = strb.wrBeatLo;
  assign beatHi = strb.wrBeatHi;
  assign capLo  = strb.rdCapLo;
  assign capHi  = strb.rdCapHi;

  // request staging
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddrQ <= '0;
      wrBufQ  <= '0;
      enBufQ  <= '0;
      rdAddrQ <= '0;
    end else begin
      if (strb.wrLaunch) begin
        wrAddrQ <= wrAddr;
        wrBufQ  <= wrData;
        enBufQ  <= wrByteEn;
      end
      if (strb.rdLaunch) begin
        rdAddrQ <= rdAddr;
      end
    end
  end

  // choose which pair of the staged burst goes out next
  always_comb begin
    if (beatHi) begin
      pairData = wrBufQ[PAIR_W +: PAIR_W];
      pairEn   = enBufQ[PAIR_B +: PAIR_B];
    end else begin
      pairData = wrBufQ[0 +: PAIR_W];
      pairEn   = enBufQ[0 +: PAIR_B];
    end
  end

  // write beat pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      riseQ     <= '0;
      fallQ     <= '0;
      selRiseNQ <= '1;
      selFallNQ <= '1;
    end else if (beatLo || beatHi) begin
      riseQ     <= pairData[0 +: DATA_W];
      fallQ     <= pairData[DATA_W +: DATA_W];
      selRiseNQ <= ~pairEn[0 +: BYTES];
      selFallNQ <= ~pairEn[BYTES +: BYTES];
    end else begin
      riseQ     <= '0;
      fallQ     <= '0;
      selRiseNQ <= '1;
      selFallNQ <= '1;
    end
  end

  assign memWrAddr       = wrAddrQ;
  assign memRdAddr       = rdAddrQ;
  assign memWrDataRise   = riseQ;
  assign memWrDataFall   = fallQ;
  assign memByteSelRiseN = selRiseNQ;
  assign memByteSelFallN = selFallNQ;

  // read capture and return format
  logic            validQ, lastQ;
  logic [RD_W-1:0] dataQ;

  generate
    if (PACKED_RD != 0) begin : g_packed
      logic [PAIR_W-1:0] loHoldQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          loHoldQ <= '0;
          dataQ   <= '0;
          validQ  <= 1'b0;
          lastQ   <= 1'b0;
        end else begin
          validQ <= capHi;
          lastQ  <= capHi;
          if (capLo) loHoldQ <= {memRdDataFall, memRdDataRise};
          if (capHi) dataQ   <= {memRdDataFall, memRdDataRise, loHoldQ};
        end
      end

      // R9
      // packed_single_chk
      packed_single_chk: assert property (@(posedge clk) disable iff (!rstN)
        validQ |-> lastQ && !$past(validQ));
    end else begin : g_beat
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          dataQ  <= '0;
          validQ <= 1'b0;
          lastQ  <= 1'b0;
        end else begin
          validQ <= capLo || capHi;
          lastQ  <= capHi;
          if (capLo || capHi) dataQ <= {memRdDataFall, memRdDataRise};
        end
      end

      // R8
      // beat_pair_chk
      beat_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
        lastQ |-> validQ && $past(validQ) && !$past(lastQ));
    end
  endgenerate

  assign rdDataValid = validQ;
  assign rdLast      = lastQ;
  assign rdData      = dataQ;

  // R3
  // bsel_idle_chk
  bsel_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(beatLo) && !$past(beatHi) |-> (&selRiseNQ) && (&selFallNQ) && riseQ == '0);

endmodule

// File: rtl/qdr_burst_ctrl.sv
module qdr_burst_ctrl
  import qdr_burst_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 16,
  parameter int PACKED_RD  = 0,
  parameter int RD_CAP_LAT = 2
) (
  input  logic                                      clk,
  input  logic                                      rstN,
  input  logic                                      wrValid,
  output logic                                      wrReady,
  input  logic [ADDR_W-1:0]                         wrAddr,
  input  logic [BURST_LEN*DATA_W-1:0]               wrData,
  input  logic [BURST_LEN*(DATA_W/8)-1:0]           wrByteEn,
  input  logic                                      rdValid,
  output logic                                      rdReady,
  input  logic [ADDR_W-1:0]                         rdAddr,
  output logic                                      rdDataValid,
  output logic                                      rdLast,
  output logic [(PACKED_RD != 0 ? 4 : 2)*DATA_W-1:0] rdData,
  output logic                                      memWrSelN,
  output logic [ADDR_W-1:0]                         memWrAddr,
  output logic [DATA_W/8-1:0]                       memByteSelRiseN,
  output logic [DATA_W/8-1:0]                       memByteSelFallN,
  output logic [DATA_W-1:0]                         memWrDataRise,
  output logic [DATA_W-1:0]                         memWrDataFall,
  output logic                                      memRdSelN,
  output logic [ADDR_W-1:0]                         memRdAddr,
  input  logic [DATA_W-1:0]                         memRdDataRise,
  input  logic [DATA_W-1:0]                         memRdDataFall
);

  seqStrobes_t strb;

  qdr_burst_seq #(
    .RD_CAP_LAT(RD_CAP_LAT)
  ) i_seq (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .wrReady   (wrReady),
    .rdValid   (rdValid),
    .rdReady   (rdReady),
    .memWrSelN (memWrSelN),
    .memRdSelN (memRdSelN),
    .strb      (strb)
  );

  qdr_burst_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PACKED_RD(PACKED_RD)
  ) i_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strb            (strb),
    .wrAddr          (wrAddr),
    .wrData          (wrData),
    .wrByteEn        (wrByteEn),
    .rdAddr          (rdAddr),
    .rdDataValid     (rdDataValid),
    .rdLast          (rdLast),
    .rdData          (rdData),
    .memWrAddr       (memWrAddr),
    .memByteSelRiseN (memByteSelRiseN),
    .memByteSelFallN (memByteSelFallN),
    .memWrDataRise   (memWrDataRise),
    .memWrDataFall   (memWrDataFall),
    .memRdAddr       (memRdAddr),
    .memRdDataRise   (memRdDataRise),
    .memRdDataFall   (memRdDataFall)
  );

endmodule

// File: tb/test_qdr_burst_ctrl.sv
module test_qdr_burst_ctrl;

  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NB = DW / 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic            wrValid = 1'b0, rdValid = 1'b0;
  logic [AW-1:0]   wrAddr = '0, rdAddr = '0;
  logic [4*DW-1:0] wrData = '0;
  logic [4*NB-1:0] wrByteEn = '0;
  logic [DW-1:0]   memRdDataRise = 16'hDEAD, memRdDataFall = 16'hBEEF;

  logic            wrReady, rdReady, rdDataValid, rdLast;
  logic [2*DW-1:0] rdData;
  logic            memWrSelN, memRdSelN;
  logic [AW-1:0]   memWrAddr, memRdAddr;
  logic [NB-1:0]   memByteSelRiseN, memByteSelFallN;
  logic [DW-1:0]   memWrDataRise, memWrDataFall;

  logic            pkWrReady, pkRdReady, pkValid, pkLast;
  logic [4*DW-1:0] pkData;
  logic            pkWrSelN, pkRdSelN;
  logic [AW-1:0]   pkWrAddr, pkRdAddr;
  logic [NB-1:0]   pkSelRiseN, pkSelFallN;
  logic [DW-1:0]   pkRise, pkFall;

  qdr_burst_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PACKED_RD(0)) i_qdr_burst_ctrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr),
    .wrData(wrData), .wrByteEn(wrByteEn), .rdValid(rdValid), .rdReady(rdReady),
    .rdAddr(rdAddr), .rdDataValid(rdDataValid), .rdLast(rdLast), .rdData(rdData),
    .memWrSelN(memWrSelN), .memWrAddr(memWrAddr), .memByteSelRiseN(memByteSelRiseN),
    .memByteSelFallN(memByteSelFallN), .memWrDataRise(memWrDataRise),
    .memWrDataFall(memWrDataFall), .memRdSelN(memRdSelN), .memRdAddr(memRdAddr),
    .memRdDataRise(memRdDataRise), .memRdDataFall(memRdDataFall));

  qdr_burst_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PACKED_RD(1)) i_qdr_burst_ctrl_pk (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrReady(pkWrReady), .wrAddr(wrAddr),
    .wrData(wrData), .wrByteEn(wrByteEn), .rdValid(rdValid), .rdReady(pkRdReady),
    .rdAddr(rdAddr), .rdDataValid(pkValid), .rdLast(pkLast), .rdData(pkData),
    .memWrSelN(pkWrSelN), .memWrAddr(pkWrAddr), .memByteSelRiseN(pkSelRiseN),
    .memByteSelFallN(pkSelFallN), .memWrDataRise(pkRise),
    .memWrDataFall(pkFall), .memRdSelN(pkRdSelN), .memRdAddr(pkRdAddr),
    .memRdDataRise(memRdDataRise), .memRdDataFall(memRdDataFall));

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] initWord(input int i);
    return DW'(i * 16'h0101) ^ 16'h5A3C;
  endfunction

  // behavioural memory, driven by the beat-mode instance's pins
  logic [DW-1:0] mem [256];
  logic [DW-1:0] shadow [256];
  logic [AW-1:0] wa1, wa2, ra1, ra2;
  logic wv1 = 1'b0, wv2 = 1'b0, rv1 = 1'b0, rv2 = 1'b0;

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
      input logic [DW-1:0] nw, input logic [NB-1:0] selN);
    logic [DW-1:0] r = old;
    for (int b = 0; b < NB; b++) if (!selN[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = initWord(i);
      shadow[i] = initWord(i);
    end
  end

  always @(posedge clk) begin
    wv1 <= !memWrSelN;
    wa1 <= memWrAddr;
    wv2 <= wv1;
    wa2 <= wa1;
    if (wv1) begin
      mem[wa1]      <= merge(mem[wa1], memWrDataRise, memByteSelRiseN);
      mem[wa1 + 1'b1] <= merge(mem[wa1 + 1'b1], memWrDataFall, memByteSelFallN);
    end
    if (wv2) begin
      mem[wa2 + 2'd2] <= merge(mem[wa2 + 2'd2], memWrDataRise, memByteSelRiseN);
      mem[wa2 + 2'd3] <= merge(mem[wa2 + 2'd3], memWrDataFall, memByteSelFallN);
    end
    rv1 <= !memRdSelN;
    ra1 <= memRdAddr;
    rv2 <= rv1;
    ra2 <= ra1;
    if (rv1) begin
      memRdDataRise <= mem[ra1];
      memRdDataFall <= mem[ra1 + 1'b1];
    end else if (rv2) begin
      memRdDataRise <= mem[ra2 + 2'd2];
      memRdDataFall <= mem[ra2 + 2'd3];
    end else begin
      memRdDataRise <= 16'hDEAD;
      memRdDataFall <= 16'hBEEF;
    end
  end

  // strobe counters for the streaming pattern
  bit countEn = 1'b0;
  int beatValidCnt = 0, beatLastCnt = 0, pkValidCnt = 0;
  always @(negedge clk) begin
    if (countEn) begin
      if (rdDataValid) beatValidCnt++;
      if (rdDataValid && rdLast) beatLastCnt++;
      if (pkValid) pkValidCnt++;
    end
  end

  task automatic doWrite(input logic [AW-1:0] a, input logic [4*DW-1:0] d,
                         input logic [4*NB-1:0] en);
    @(negedge clk);
    while (!wrReady) @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d; wrByteEn = en;
    @(negedge clk);  // cycle t
    wrValid = 1'b0;
    chk(memWrSelN == 1'b0, "R2 write select", 64'(memWrSelN), 64'd0);
    chk(memWrAddr == a, "R2 write address", 64'(memWrAddr), 64'(a));
    chk(wrReady == 1'b0, "R4 ready after launch", 64'(wrReady), 64'd0);
    for (int i = 0; i < 4; i++)
      for (int b = 0; b < NB; b++)
        if (en[i*NB + b]) shadow[AW'(a + i)][8*b +: 8] = d[i*DW + 8*b +: 8];
    @(negedge clk);  // t+1
    chk(memWrSelN == 1'b1, "R4 select one cycle", 64'(memWrSelN), 64'd1);
    chk({memWrDataFall, memWrDataRise} == d[0 +: 2*DW], "R3 beats 0/1",
        64'({memWrDataFall, memWrDataRise}), 64'(d[0 +: 2*DW]));
    chk({memByteSelFallN, memByteSelRiseN} == ~en[0 +: 2*NB], "R3 selects 0/1",
        64'({memByteSelFallN, memByteSelRiseN}), 64'(~en[0 +: 2*NB]));
    @(negedge clk);  // t+2
    chk({memWrDataFall, memWrDataRise} == d[2*DW +: 2*DW], "R3 beats 2/3",
        64'({memWrDataFall, memWrDataRise}), 64'(d[2*DW +: 2*DW]));
    chk({memByteSelFallN, memByteSelRiseN} == ~en[2*NB +: 2*NB], "R3 selects 2/3",
        64'({memByteSelFallN, memByteSelRiseN}), 64'(~en[2*NB +: 2*NB]));
    @(negedge clk);  // t+3
    chk(&{memByteSelFallN, memByteSelRiseN} && memWrDataRise == '0 && memWrDataFall == '0,
        "R3 idle pins", 64'({memByteSelFallN, memByteSelRiseN, memWrDataRise}), 64'hF0000);
  endtask

  task automatic doRead(input logic [AW-1:0] a);
    logic [4*DW-1:0] exp;
    for (int i = 0; i < 4; i++) exp[i*DW +: DW] = shadow[AW'(a + i)];
    @(negedge clk);
    while (!rdReady) @(negedge clk);
    rdValid = 1'b1; rdAddr = a;
    @(negedge clk);  // t
    rdValid = 1'b0;
    chk(memRdSelN == 1'b0, "R5 read select", 64'(memRdSelN), 64'd0);
    chk(memRdAddr == a, "R5 read address", 64'(memRdAddr), 64'(a));
    chk(rdReady == 1'b0, "R6 ready after launch", 64'(rdReady), 64'd0);
    @(negedge clk);  // t+1
    chk(memRdSelN == 1'b1, "R6 select one cycle", 64'(memRdSelN), 64'd1);
    @(negedge clk);  // t+2
    chk(!rdDataValid && !pkValid, "R7 nothing before capture",
        64'({rdDataValid, pkValid}), 64'd0);
    @(negedge clk);  // t+3
    chk(rdDataValid && !rdLast, "R8 first strobe", 64'({rdDataValid, rdLast}), 64'b10);
    chk(rdData == exp[0 +: 2*DW], "R7 R8 words A/A+1", 64'(rdData), 64'(exp[0 +: 2*DW]));
    chk(!pkValid, "R9 no early packed strobe", 64'(pkValid), 64'd0);
    @(negedge clk);  // t+4
    chk(rdDataValid && rdLast, "R8 last strobe", 64'({rdDataValid, rdLast}), 64'b11);
    chk(rdData == exp[2*DW +: 2*DW], "R7 R8 words A+2/A+3",
        64'(rdData), 64'(exp[2*DW +: 2*DW]));
    chk(pkValid && pkLast, "R9 packed strobe", 64'({pkValid, pkLast}), 64'b11);
    chk(pkData == exp, "R9 packed burst", pkData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(memWrSelN && memRdSelN && pkWrSelN && pkRdSelN, "R1 selects in reset",
        64'({memWrSelN, memRdSelN}), 64'b11);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(wrReady && rdReady, "R1 readies", 64'({wrReady, rdReady}), 64'b11);
    chk(!rdDataValid && !pkValid, "R1 read valid", 64'({rdDataValid, pkValid}), 64'd0);
    chk(&{memByteSelFallN, memByteSelRiseN} && memWrDataRise == '0 && memWrDataFall == '0,
        "R1 write pins", 64'({memByteSelFallN, memByteSelRiseN}), 64'hF);
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      chk(memWrSelN && memRdSelN, "R11 idle selects", 64'({memWrSelN, memRdSelN}), 64'b11);
    end

    // write sweep: spread addresses, varied masks, wrap at the top
    for (int k = 0; k < 16; k++) begin
      logic [4*DW-1:0] d;
      logic [7:0] en;
      for (int i = 0; i < 4; i++) d[i*DW +: DW] = DW'(k * 16'h1111 + i * 16'h0203 + 16'h0F00);
      en = (k == 0) ? 8'hFF : 8'((k * 8'h3B) ^ 8'hA5);
      doWrite(AW'(k * 17), d, en);
    end

    // read back every burst and one untouched region
    for (int k = 0; k < 16; k++) doRead(AW'(k * 17));
    doRead(8'h80);

    // stream: both ports held busy for eight cycles
    @(negedge clk);
    while (!(wrReady && rdReady)) @(negedge clk);
    beatValidCnt = 0; beatLastCnt = 0; pkValidCnt = 0;
    countEn = 1'b1;
    wrValid = 1'b1; rdValid = 1'b1;
    wrAddr = 8'h40; rdAddr = 8'h40; wrData = '1; wrByteEn = '0;
    for (int j = 0; j < 8; j++) begin
      @(negedge clk);
      chk(memWrSelN == (j % 2 == 1), "R4 alternating launches",
          64'(memWrSelN), 64'(j % 2 == 1));
      chk(memRdSelN == (j % 2 == 1), "R6 alternating launches",
          64'(memRdSelN), 64'(j % 2 == 1));
      chk(memRdSelN == memWrSelN, "R10 joint launch",
          64'({memRdSelN, memWrSelN}), 64'({memWrSelN, memWrSelN}));
      chk(wrReady == (j % 2 == 1), "R4 ready pattern", 64'(wrReady), 64'(j % 2 == 1));
    end
    wrValid = 1'b0; rdValid = 1'b0;
    repeat (6) @(negedge clk);
    countEn = 1'b0;
    chk(beatValidCnt == 8, "R8 beat strobes in stream", 64'(beatValidCnt), 64'd8);
    chk(beatLastCnt == 4, "R8 last strobes in stream", 64'(beatLastCnt), 64'd4);
    chk(pkValidCnt == 4, "R9 packed strobes in stream", 64'(pkValidCnt), 64'd4);
    doRead(8'h40);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule